// File: doc/BRIEF.md
# Colour Palette Loader

This block holds a colour lookup table of 256 entries. Each entry is an 8-bit red, green and blue triplet. A host loads the table through a 32-bit write port that decodes a 16-byte register window. The host first writes a starting entry number to the index register. It then streams colour bytes, one at a time, into a single data register. The block keeps its own component phase, so consecutive data writes go to red, then green, then blue of the current entry. After the blue byte, the block moves on to the next entry by itself. No entry has its own address.

On the display side, a pixel-value port reads the table and returns the stored 24-bit colour one clock later. Bus reads from the window always return zero. Reset loads a known pattern into the table.

Top module: `pal_dac_loader`

## Requirements
- R1: A full-word write to byte offset 0x0 loads the current index from write-data bits 31:24 and sets the component phase to red.
- R2: Full-word writes to byte offset 0x4 store write-data bits 31:24 into a component of the entry at the current index. The first such write after an index load goes to red, the second to green, the third to blue.
- R3: The blue write increments the index by one modulo 256, so entry 255 wraps to entry 0. The phase returns to red.
- R4: These writes change neither the table, the index nor the phase:
  - writes to offsets 0x8 and 0xC;
  - writes to any offset that is not a multiple of four;
  - writes whose byte enables are not all four set.
- R5: The bus read-data output is zero at all times.
- R6: After reset, entries 0 to 254 read 0x000000 and entry 255 reads 0xFFFFFF. Index and phase are both zero, which means entry 0 and red.
- R7: An index write in the middle of a triplet abandons the remaining components of that entry. Components already written keep their new values, and the components not yet written keep their old values. The next data write goes to red of the new index.
- R8: The lookup output `pix_rgb_o` presents the entry selected by `pix_i` after exactly one rising clock edge. Red is in bits 23:16, green in 15:8 and blue in 7:0.
- R9: If a data write and a lookup address the same entry in the same cycle, the lookup returns the entry's value from before the write. The new value appears on the following lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Write strobe, one cycle per write |
| bus_addr_i | input | 4 | Byte offset within the 16-byte window |
| bus_be_i | input | 4 | Byte enables; only 4'hF is accepted |
| bus_wdata_i | input | 32 | Write data; the payload is in bits 31:24 |
| bus_rdata_o | output | 32 | Read data, always zero |
| pix_i | input | 8 | Pixel value used as the lookup address |
| pix_rgb_o | output | 24 | Registered colour {red, green, blue} |

## Verification
The pixel lookup and a data write can touch the same table entry in the same cycle. This happens during normal operation, because the display keeps scanning while the host is reloading colours. The bench sets this up directly: it points `pix_i` at the entry being loaded and issues the red write at the same edge. It then expects the old colour on that cycle and the new colour one lookup later. A second overlap occurs when an index write lands while a triplet is half loaded. The bench checks it by reading back both the abandoned entry and the newly addressed entry.

// File: rtl/pal_pkg.sv
package pal_pkg;
  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2
  } phase_e;

  localparam int unsigned NUM_COMP = 3;
  localparam logic [3:0]  OFS_INDEX = 4'h0;
  localparam logic [3:0]  OFS_DATA  = 4'h4;
endpackage

// File: rtl/pal_bus_decode.sv
module pal_bus_decode #(
  parameter int unsigned AW     = 4,
  parameter int unsigned DW     = 32,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW/8-1:0]   be_i,
  input  logic [DW-1:0]     wdata_i,
  output logic              idx_wr_o,
  output logic              dat_wr_o,
  output logic [BYTE_W-1:0] byte_o
);
  import pal_pkg::*;

  localparam int unsigned LSB = DW - BYTE_W;

  logic full_word;
  logic unused_low;

  assign full_word = (be_i == '1);
  assign idx_wr_o  = we_i && full_word && (addr_i == AW'(OFS_INDEX));
  assign dat_wr_o  = we_i && full_word && (addr_i == AW'(OFS_DATA));
  assign byte_o    = wdata_i[DW-1:LSB];
  assign unused_low = ^wdata_i[LSB-1:0];
endmodule

// File: rtl/pal_seq.sv
module pal_seq #(
  parameter int unsigned IDX_W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     idx_wr_i,
  input  logic                     dat_wr_i,
  input  logic [IDX_W-1:0]         idx_val_i,
  output logic [IDX_W-1:0]         idx_o,
  output pal_pkg::phase_e          phase_o,
  output logic [pal_pkg::NUM_COMP-1:0] comp_we_o
);
  import pal_pkg::*;

  logic [IDX_W-1:0] idx_q;
  phase_e           phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q   <= '0;
      phase_q <= PH_RED;
    end else if (idx_wr_i) begin
      idx_q   <= idx_val_i;
      phase_q <= PH_RED;
    end else if (dat_wr_i) begin
      unique case (phase_q)
        PH_RED:  phase_q <= PH_GRN;
        PH_GRN:  phase_q <= PH_BLU;
        default: begin
          phase_q <= PH_RED;
          idx_q   <= idx_q + 1'b1;
        end
      endcase
    end
  end

  always_comb begin
    comp_we_o = '0;
    if (dat_wr_i && !idx_wr_i) comp_we_o[phase_q] = 1'b1;
  end

  assign idx_o   = idx_q;
  assign phase_o = phase_q;

  AST_PHASE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q inside {PH_RED, PH_GRN, PH_BLU});                       // R2
  AST_IDX_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_wr_i |=> (idx_q == $past(idx_val_i)) && (phase_q == PH_RED)); // R1
  AST_IDX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_wr_i && !idx_wr_i && phase_q == PH_BLU)
      |=> (idx_q == IDX_W'($past(idx_q) + 1'b1)) && (phase_q == PH_RED)); // R3
  AST_PHASE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_wr_i && !idx_wr_i && phase_q != PH_BLU)
      |=> $stable(idx_q) && (phase_q != $past(phase_q)));            // R2
endmodule

// File: rtl/pal_table.sv
module pal_table #(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned COMP_W = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [pal_pkg::NUM_COMP-1:0]  we_i,
  input  logic [IDX_W-1:0]              waddr_i,
  input  logic [COMP_W-1:0]             wdata_i,
  input  logic [IDX_W-1:0]              raddr_i,
  output logic [pal_pkg::NUM_COMP*COMP_W-1:0] rdata_o
);
  import pal_pkg::*;

  localparam int unsigned DEPTH = 1 << IDX_W;

  for (genvar c = 0; c < NUM_COMP; c++) begin : g_comp
    logic [COMP_W-1:0] mem_q [DEPTH];
    logic [COMP_W-1:0] rd_q;

    // reset pattern: top entry full scale, rest zero
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < DEPTH; i++)
          mem_q[i] <= (i == DEPTH - 1) ? '1 : '0;
      end else if (we_i[c]) begin
        mem_q[waddr_i] <= wdata_i;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) rd_q <= '0;
      else         rd_q <= mem_q[raddr_i];
    end

    // component 0 (red) lands in the top byte
    assign rdata_o[(NUM_COMP-1-c)*COMP_W +: COMP_W] = rd_q;
  end

  AST_WE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(we_i));                                                // R2
endmodule

// File: rtl/pal_dac_loader.sv
module pal_dac_loader #(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned COMP_W = 8,
  parameter int unsigned BUS_DW = 32,
  parameter int unsigned WIN_AW = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  bus_we_i,
  input  logic [WIN_AW-1:0]     bus_addr_i,
  input  logic [BUS_DW/8-1:0]   bus_be_i,
  input  logic [BUS_DW-1:0]     bus_wdata_i,
  output logic [BUS_DW-1:0]     bus_rdata_o,
  input  logic [IDX_W-1:0]      pix_i,
  output logic [3*COMP_W-1:0]   pix_rgb_o
);
  import pal_pkg::*;

  logic                idx_wr;
  logic                dat_wr;
  logic [COMP_W-1:0]   wr_byte;
  logic [IDX_W-1:0]    cur_idx;
  phase_e              cur_phase;
  logic [NUM_COMP-1:0] comp_we;
  logic [IDX_W-1:0]    idx_val;

  pal_bus_decode #(
    .AW(WIN_AW), .DW(BUS_DW), .BYTE_W(COMP_W)
  ) u_decode (
    .we_i     (bus_we_i),
    .addr_i   (bus_addr_i),
    .be_i     (bus_be_i),
    .wdata_i  (bus_wdata_i),
    .idx_wr_o (idx_wr),
    .dat_wr_o (dat_wr),
    .byte_o   (wr_byte)
  );

  assign idx_val = IDX_W'(wr_byte);

  pal_seq #(.IDX_W(IDX_W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .idx_wr_i  (idx_wr),
    .dat_wr_i  (dat_wr),
    .idx_val_i (idx_val),
    .idx_o     (cur_idx),
    .phase_o   (cur_phase),
    .comp_we_o (comp_we)
  );

  pal_table #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_table (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (comp_we),
    .waddr_i (cur_idx),
    .wdata_i (wr_byte),
    .raddr_i (pix_i),
    .rdata_o (pix_rgb_o)
  );

  assign bus_rdata_o = '0;

  AST_NO_PARTIAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_be_i != '1) |=> $stable(cur_idx) && $stable(cur_phase)); // R4
  AST_NO_SPARE_OFS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i != WIN_AW'(OFS_INDEX) && bus_addr_i != WIN_AW'(OFS_DATA))
      |=> $stable(cur_idx) && $stable(cur_phase));                  // R4
  AST_WE_NEEDS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (comp_we != '0) |-> (bus_we_i && bus_addr_i == WIN_AW'(OFS_DATA))); // R2
endmodule

// File: tb/pal_dac_loader_bench.sv
module pal_dac_loader_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  pix = '0;
  logic [23:0] rgb;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pal_dac_loader u_pal_dac_loader (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_be_i(be), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .pix_i(pix), .pix_rgb_o(rgb)
  );

  // {addr, be, byte, lookup pixel, expected rgb}
  typedef struct packed {
    logic [3:0]  a;
    logic [3:0]  e;
    logic [7:0]  d;
    logic [7:0]  p;
    logic [23:0] x;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{4'h0, 4'hF, 8'h10, 8'h10, 24'h000000}, // R1 index load
    '{4'h4, 4'hF, 8'h11, 8'h10, 24'h110000}, // R2 red
    '{4'h4, 4'hF, 8'h22, 8'h10, 24'h112200}, // R2 green
    '{4'h4, 4'hF, 8'h33, 8'h10, 24'h112233}, // R2 blue
    '{4'h4, 4'hF, 8'h44, 8'h11, 24'h440000}, // R3 auto increment
    '{4'h0, 4'hF, 8'hFF, 8'hFF, 24'hFFFFFF}, // R1 jump to top entry
    '{4'h4, 4'hF, 8'h01, 8'hFF, 24'h01FFFF}, // R2
    '{4'h4, 4'hF, 8'h02, 8'hFF, 24'h0102FF}, // R2
    '{4'h4, 4'hF, 8'h03, 8'hFF, 24'h010203}, // R2
    '{4'h4, 4'hF, 8'hAA, 8'h00, 24'hAA0000}, // R3 wrap 255 -> 0
    '{4'h8, 4'hF, 8'hBB, 8'h00, 24'hAA0000}, // R4 spare offset
    '{4'hC, 4'hF, 8'hBB, 8'h00, 24'hAA0000}, // R4 spare offset
    '{4'h4, 4'h8, 8'hBB, 8'h00, 24'hAA0000}, // R4 partial enables
    '{4'h5, 4'hF, 8'hBB, 8'h00, 24'hAA0000}, // R4 unaligned
    '{4'h4, 4'hF, 8'hCC, 8'h00, 24'hAACC00}, // R4 phase untouched -> green
    '{4'h0, 4'hF, 8'h11, 8'h11, 24'h440000}, // R7 abandon mid triplet
    '{4'h4, 4'hF, 8'h55, 8'h11, 24'h550000}, // R7 restart at red
    '{4'h0, 4'hF, 8'h00, 8'h00, 24'hAACC00}  // R7 abandoned entry kept
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [3:0] b, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; be = b; wdata = {d, 24'h5A5A5A};
    @(negedge clk);
    check("R5", rdata, 32'h0);
    we = 1'b0; be = '0;
  endtask

  task automatic look(input logic [7:0] p, output logic [23:0] v);
    @(negedge clk);
    pix = p;
    @(negedge clk);
    v = rgb;
  endtask

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    logic [23:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R6 reset pattern
    look(8'h00, v); check("R6", {8'h0, v}, 32'h000000);
    look(8'h80, v); check("R6", {8'h0, v}, 32'h000000);
    look(8'hFE, v); check("R6", {8'h0, v}, 32'h000000);
    look(8'hFF, v); check("R6", {8'h0, v}, 32'hFFFFFF);
    check("R5", rdata, 32'h0);
    // R6 index/phase zero: first data write lands in red of entry 0
    bus_wr(4'h4, 4'hF, 8'h9C);
    look(8'h00, v); check("R6", {8'h0, v}, 32'h9C0000);

    for (int i = 0; i < NV; i++) begin
      bus_wr(VEC[i].a, VEC[i].e, VEC[i].d);
      look(VEC[i].p, v);
      check($sformatf("vec%0d R1-R7", i), {8'h0, v}, {8'h0, VEC[i].x});
    end

    // R8 latency: output holds until the edge after pix changes
    look(8'h10, v);
    @(negedge clk); pix = 8'hFF;
    #1 check("R8", {8'h0, rgb}, 32'h112233);
    @(negedge clk);
    check("R8", {8'h0, rgb}, 32'h010203);

    // R9 same-cycle write and lookup of the same entry
    bus_wr(4'h0, 4'hF, 8'h20);
    @(negedge clk);
    pix = 8'h20; we = 1'b1; addr = 4'h4; be = 4'hF; wdata = 32'h77000000;
    @(negedge clk);
    we = 1'b0; be = '0;
    check("R9", {8'h0, rgb}, 32'h000000);
    @(negedge clk);
    check("R9", {8'h0, rgb}, 32'h770000);

    // R6 reset mid-run restores the pattern
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    look(8'h20, v); check("R6", {8'h0, v}, 32'h000000);
    look(8'hFF, v); check("R6", {8'h0, v}, 32'hFFFFFF);
    bus_wr(4'h4, 4'hF, 8'h66);
    look(8'h00, v); check("R6", {8'h0, v}, 32'h660000);

    summary();
  end
endmodule